// File: doc/BRIEF.md
# Floating-Point Unordered Compare Unit

This block compares two IEEE-754 binary64 operands and produces a 4-bit condition field. The field has a less bit, a greater bit, an equal bit and an unordered bit. The field is written into one of eight 4-bit slots of a 32-bit condition register, and the other seven slots keep their contents. The same result is also loaded into a 5-bit result-class status field as a one-hot code.

A signalling NaN on either input sets a sticky invalid-SNaN flag. A sticky summary bit is set each time that flag rises. An invalid-compare flag exists beside them, and this unordered compare never sets it, even for quiet NaNs. The sticky flags are cleared by an external clear strobe.

A compare is started with a one-cycle valid strobe. Its results are registered on the next clock edge, together with a one-cycle done pulse. Single-precision values held in double format go through the same path.

Top module: `fucmp_top`

## Requirements
- R1: If either operand is a NaN (exponent all ones and fraction nonzero), the result field is 4'b1000: unordered=1, and less, greater and equal are all 0.
- R2: If either operand is a signalling NaN (exponent all ones, fraction nonzero, fraction MSB bit 51 = 0), snanFlag becomes 1 and stays 1. invCmpFlag is never set by any compare, including compares with quiet NaNs.
- R3: +0 (64'h0) and -0 (64'h8000000000000000) compare equal in every pairing, giving field 4'b0100.
- R4: For ordered operands, the field bit order is less = bit 0, greater = bit 1, equal = bit 2 and unordered = bit 3. Exactly one of the bits is set, according to the numeric order of A against B across normals, denormals and infinities.
- R5: The field is written to condReg[4*k+3:4*k], where k is fieldIdx (0 to 7). All other bits of condReg are unchanged.
- R6: statusClass is loaded with 5'b01000 for less, 5'b00100 for greater, 5'b00010 for equal and 5'b00001 for unordered.
- R7: summaryFlag is set in the same cycle that snanFlag goes from 0 to 1, and it is sticky.
- R8: statusClr clears snanFlag, summaryFlag and invCmpFlag on the next edge. A clear and a compare in the same cycle clear the flags first and then apply the compare's set.
- R9: All results appear one clock edge after the inValid cycle. done is high for exactly that one cycle for each valid cycle.
- R10: After reset, condReg, statusClass, all flags and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Start a compare this cycle |
| statusClr | input | 1 | Clear the sticky status flags |
| opA | input | 64 | Operand A, binary64 |
| opB | input | 64 | Operand B, binary64 |
| fieldIdx | input | 3 | Destination slot index |
| condReg | output | 32 | Condition register, eight 4-bit slots |
| statusClass | output | 5 | One-hot result-class code |
| snanFlag | output | 1 | Sticky invalid-SNaN flag |
| invCmpFlag | output | 1 | Sticky invalid-compare flag |
| summaryFlag | output | 1 | Sticky exception summary |
| done | output | 1 | Result-ready pulse |

## Verification
The checker assumes that opA, opB and fieldIdx are sampled only in a cycle where inValid is high. It also assumes that their values in that cycle fully determine the next condReg slot and status code, so it remembers the previous cycle's inputs and condition register rather than any internal state. It treats statusClr as a plain input that may come at any time. The bench keeps inputs changing only at the falling edge and holds inValid low during reset. Beside its directed zero, NaN and infinity cases, it mixes random bit patterns, valid pulses, slot indices and occasional clears, including a clear in the same cycle as a compare.

// File: rtl/fucmp_pkg.sv
package fucmp_pkg;
  // bit positions inside one condition slot (consumed by branch logic)
  localparam int unsigned BIT_LT = 0;
  localparam int unsigned BIT_GT = 1;
  localparam int unsigned BIT_EQ = 2;
  localparam int unsigned BIT_UN = 3;
  localparam int unsigned SLOT_W = 4;

  typedef enum logic [4:0] {
    CLS_NONE = 5'b00000,
    CLS_UN   = 5'b00001,
    CLS_EQ   = 5'b00010,
    CLS_GT   = 5'b00100,
    CLS_LT   = 5'b01000
  } cmpClass_e;

  typedef struct packed {
    logic load;
    logic clear;
  } ctlStrobe_t;
endpackage

// File: rtl/fucmp_ctrl.sv
module fucmp_ctrl
  import fucmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inValid,
  input  logic       statusClr,
  output ctlStrobe_t strobe,
  output logic       done
);
  always_comb begin
    strobe.load  = inValid;
    strobe.clear = statusClr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= inValid;
  end
endmodule

// File: rtl/fucmp_datapath.sv
module fucmp_datapath
  import fucmp_pkg::*;
#(
  parameter int unsigned EXP_W = 11,
  parameter int unsigned FRAC_W = 52,
  parameter int unsigned SLOTS = 8,
  localparam int unsigned DATA_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned IDX_W = $clog2(SLOTS),
  localparam int unsigned CR_W = SLOTS * SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IDX_W-1:0]  fieldIdx,
  output logic [CR_W-1:0]   condReg,
  output logic [4:0]        statusClass,
  output logic              snanFlag,
  output logic              invCmpFlag,
  output logic              summaryFlag
);
  localparam logic SET_INV_CMP = 1'b0; // unordered compare never raises it

  function automatic logic isNan(input logic [DATA_W-1:0] v);
    return (&v[DATA_W-2:FRAC_W]) && (|v[FRAC_W-1:0]);
  endfunction

  function automatic logic isSnan(input logic [DATA_W-1:0] v);
    return isNan(v) && !v[FRAC_W-1];
  endfunction

  function automatic logic [DATA_W-1:0] orderKey(input logic [DATA_W-1:0] v);
    return v[DATA_W-1] ? ~v : (v ^ {1'b1, {(DATA_W-1){1'b0}}});
  endfunction

  logic nanAny, snanAny, bothZero, keyLess, keyGreater;
  logic [SLOT_W-1:0] newField;
  cmpClass_e newClass;

  always_comb begin
    nanAny     = isNan(opA) || isNan(opB);
    snanAny    = isSnan(opA) || isSnan(opB);
    bothZero   = (opA[DATA_W-2:0] == '0) && (opB[DATA_W-2:0] == '0);
    keyLess    = orderKey(opA) < orderKey(opB);
    keyGreater = orderKey(opA) > orderKey(opB);
    newField   = '0;
    if (nanAny) begin
      newField[BIT_UN] = 1'b1;
      newClass = CLS_UN;
    end else if (bothZero || (!keyLess && !keyGreater)) begin
      newField[BIT_EQ] = 1'b1;
      newClass = CLS_EQ;
    end else if (keyLess) begin
      newField[BIT_LT] = 1'b1;
      newClass = CLS_LT;
    end else begin
      newField[BIT_GT] = 1'b1;
      newClass = CLS_GT;
    end
  end

  // condition slots
  logic [SLOT_W-1:0] slotQ [SLOTS];
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slotQ[s] <= '0;
      else if (strobe.load && fieldIdx == IDX_W'(s)) slotQ[s] <= newField;
    end
    assign condReg[s*SLOT_W +: SLOT_W] = slotQ[s];
  end

  // status
  logic snanKept, setSnan;
  assign snanKept = snanFlag && !strobe.clear;
  assign setSnan  = strobe.load && snanAny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusClass <= CLS_NONE;
      snanFlag    <= 1'b0;
      invCmpFlag  <= 1'b0;
      summaryFlag <= 1'b0;
    end else begin
      if (strobe.load) statusClass <= newClass;
      snanFlag    <= snanKept || setSnan;
      invCmpFlag  <= (invCmpFlag && !strobe.clear) || (strobe.load && SET_INV_CMP);
      summaryFlag <= (summaryFlag && !strobe.clear) || (setSnan && !snanKept);
    end
  end
endmodule

// File: rtl/fucmp_top.sv
module fucmp_top
  import fucmp_pkg::*;
#(
  parameter int unsigned EXP_W = 11,
  parameter int unsigned FRAC_W = 52,
  parameter int unsigned SLOTS = 8,
  localparam int unsigned DATA_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned IDX_W = $clog2(SLOTS),
  localparam int unsigned CR_W = SLOTS * SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              statusClr,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IDX_W-1:0]  fieldIdx,
  output logic [CR_W-1:0]   condReg,
  output logic [4:0]        statusClass,
  output logic              snanFlag,
  output logic              invCmpFlag,
  output logic              summaryFlag,
  output logic              done
);
  ctlStrobe_t strobe;

  fucmp_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .statusClr(statusClr),
    .strobe(strobe), .done(done)
  );

  fucmp_datapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SLOTS(SLOTS)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .opA(opA), .opB(opB),
    .fieldIdx(fieldIdx), .condReg(condReg), .statusClass(statusClass),
    .snanFlag(snanFlag), .invCmpFlag(invCmpFlag), .summaryFlag(summaryFlag)
  );
endmodule

// File: rtl/fucmp_checker.sv
module fucmp_checker #(
  parameter int unsigned EXP_W = 11,
  parameter int unsigned FRAC_W = 52,
  parameter int unsigned SLOTS = 8,
  localparam int unsigned DATA_W = 1 + EXP_W + FRAC_W,
  localparam int unsigned IDX_W = $clog2(SLOTS),
  localparam int unsigned CR_W = SLOTS * 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              statusClr,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [IDX_W-1:0]  fieldIdx,
  input logic [CR_W-1:0]   condReg,
  input logic [4:0]        statusClass,
  input logic              snanFlag,
  input logic              invCmpFlag,
  input logic              summaryFlag,
  input logic              done
);
  logic              prevValid;
  logic [DATA_W-1:0] prevA, prevB;
  logic [IDX_W-1:0]  prevIdx;
  logic [CR_W-1:0]   prevCond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prevValid <= 1'b0; prevA <= '0; prevB <= '0; prevIdx <= '0; prevCond <= '0;
    end else begin
      prevValid <= inValid; prevA <= opA; prevB <= opB; prevIdx <= fieldIdx; prevCond <= condReg;
    end
  end

  logic nanP, snanP, zeroP;
  logic [3:0] slotNow;
  logic [CR_W-1:0] slotMask;
  assign nanP  = ((&prevA[DATA_W-2:FRAC_W]) && (|prevA[FRAC_W-1:0])) ||
                 ((&prevB[DATA_W-2:FRAC_W]) && (|prevB[FRAC_W-1:0]));
  assign snanP = ((&prevA[DATA_W-2:FRAC_W]) && (|prevA[FRAC_W-1:0]) && !prevA[FRAC_W-1]) ||
                 ((&prevB[DATA_W-2:FRAC_W]) && (|prevB[FRAC_W-1:0]) && !prevB[FRAC_W-1]);
  assign zeroP = (prevA[DATA_W-2:0] == '0) && (prevB[DATA_W-2:0] == '0);
  assign slotNow  = condReg[prevIdx*4 +: 4];
  assign slotMask = {{(CR_W-4){1'b0}}, 4'hF} << (prevIdx * 4);

  a_r1_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
    (prevValid && nanP) |-> (slotNow == 4'b1000));
  a_r2_snan_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (prevValid && snanP) |-> snanFlag);
  a_r3_zero_equal: assert property (@(posedge clk) disable iff (!rst_n)
    (prevValid && zeroP) |-> (slotNow == 4'b0100));
  a_r5_other_slots: assert property (@(posedge clk) disable iff (!rst_n)
    prevValid |-> (((condReg ^ prevCond) & ~slotMask) == '0));
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !prevValid |-> (condReg == prevCond));
  a_r6_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $onehot(statusClass));
  a_r7_summary_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(snanFlag) |-> summaryFlag);
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done == prevValid);
endmodule

bind fucmp_top fucmp_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .SLOTS(SLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .statusClr(statusClr),
  .opA(opA), .opB(opB), .fieldIdx(fieldIdx), .condReg(condReg),
  .statusClass(statusClass), .snanFlag(snanFlag), .invCmpFlag(invCmpFlag),
  .summaryFlag(summaryFlag), .done(done)
);

// File: tb/tb_fucmp_top.sv
`timescale 1ns/1ps
module tb_fucmp_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, statusClr = 1'b0;
  logic [63:0] opA = '0, opB = '0;
  logic [2:0] fieldIdx = '0;
  logic [31:0] condReg;
  logic [4:0] statusClass;
  logic snanFlag, invCmpFlag, summaryFlag, done;

  always #2.5 clk = ~clk;

  fucmp_top dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .statusClr(statusClr),
    .opA(opA), .opB(opB), .fieldIdx(fieldIdx), .condReg(condReg),
    .statusClass(statusClass), .snanFlag(snanFlag), .invCmpFlag(invCmpFlag),
    .summaryFlag(summaryFlag), .done(done)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mCond = '0;
  logic [4:0]  mClass = '0;
  logic mSnan = 0, mSum = 0, mDone = 0;

  localparam logic [63:0] P0 = 64'h0, N0 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] P1 = 64'h3FF0_0000_0000_0000, P2 = 64'h4000_0000_0000_0000;
  localparam logic [63:0] M1 = 64'hBFF0_0000_0000_0000, M2 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] PINF = 64'h7FF0_0000_0000_0000, NINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] QNAN = 64'h7FF8_0000_0000_0000, SNAN = 64'h7FF0_0000_0000_0001;
  localparam logic [63:0] NSNAN = 64'hFFF4_0000_0000_0000, DEN = 64'h0000_0000_0000_0001;

  function automatic logic fNan(input logic [63:0] v);
    return v[62:52] == 11'h7FF && v[51:0] != 0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compareAll(input string condTag);
    chk(condTag, 64'(condReg), 64'(mCond));
    chk("R6 statusClass", 64'(statusClass), 64'(mClass));
    chk("R2 snanFlag", 64'(snanFlag), 64'(mSnan));
    chk("R2 invCmpFlag", 64'(invCmpFlag), 64'd0);
    chk("R7/R8 summaryFlag", 64'(summaryFlag), 64'(mSum));
    chk("R9 done", 64'(done), 64'(mDone));
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic step(input logic v, input logic [63:0] a, input logic [63:0] b,
                      input logic [2:0] idx, input logic clr, input string tag);
    real ra, rb;
    logic [3:0] f;
    logic sn;
    inValid = v; opA = a; opB = b; fieldIdx = idx; statusClr = clr;
    @(posedge clk);
    if (clr) begin mSnan = 0; mSum = 0; end
    mDone = v;
    if (v) begin
      ra = $bitstoreal(a); rb = $bitstoreal(b);
      if (fNan(a) || fNan(b))      begin f = 4'b1000; mClass = 5'b00001; end
      else if (ra < rb)            begin f = 4'b0001; mClass = 5'b01000; end
      else if (ra > rb)            begin f = 4'b0010; mClass = 5'b00100; end
      else                         begin f = 4'b0100; mClass = 5'b00010; end
      mCond[idx*4 +: 4] = f;
      sn = (fNan(a) && !a[51]) || (fNan(b) && !b[51]);
      if (sn) begin
        if (!mSnan) mSum = 1;
        mSnan = 1;
      end
    end
    @(negedge clk);
    compareAll(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL R9 watchdog expired actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compareAll("R10 reset condReg");
    rst_n = 1'b1;
    @(negedge clk);
    compareAll("R10 post-reset idle");

    step(1, P1, P2, 3'd0, 0, "R4 less");
    step(1, P2, P1, 3'd1, 0, "R4 greater");
    step(1, M1, M1, 3'd2, 0, "R4 equal");
    step(1, M2, M1, 3'd3, 0, "R4 negative order");
    step(1, NINF, M2, 3'd4, 0, "R4 -inf");
    step(1, PINF, DEN, 3'd5, 0, "R4 +inf vs denormal");
    step(1, DEN, P0, 3'd6, 0, "R4 denormal vs zero");
    step(1, P0, N0, 3'd7, 0, "R3 +0 vs -0");
    step(1, N0, P0, 3'd0, 0, "R3 -0 vs +0");
    step(1, N0, N0, 3'd1, 0, "R3 -0 vs -0");
    step(0, P1, P2, 3'd1, 0, "R5 idle holds");
    step(1, QNAN, P1, 3'd2, 0, "R1 qNaN A");
    step(1, P1, QNAN, 3'd3, 0, "R1 qNaN B");
    step(1, QNAN, QNAN, 3'd4, 0, "R2 qNaN no invCmp");
    step(1, SNAN, P1, 3'd5, 0, "R2 sNaN A");
    step(1, P1, NSNAN, 3'd6, 0, "R2 sNaN B again");
    step(0, P0, P0, 3'd0, 1, "R8 clear");
    step(1, NSNAN, SNAN, 3'd7, 1, "R8 clear with compare");
    step(1, P1, P1, 3'd7, 0, "R5 slot7 overwrite");
    step(1, P1, P2, 3'd0, 0, "R9 back-to-back 1");
    step(1, P2, P1, 3'd0, 0, "R9 back-to-back 2");
    step(0, P0, P0, 3'd0, 0, "R9 done drops");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      b = ($urandom % 4 == 0) ? a : {$urandom, $urandom};
      if ($urandom % 8 == 0) a[62:52] = 11'h7FF;
      if ($urandom % 8 == 0) b = {b[63], 63'h0};
      step(($urandom % 4) != 0, a, b, 3'($urandom), ($urandom % 16) == 0, "R4/R5 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule